// File: doc/BRIEF.md
# Exception and Interrupt Control Register Unit

This unit is the system-control register block of a small 32-bit RISC core. It holds four registers: the faulting data address, the processor status, the exception cause and the saved return PC. The pipeline reports synchronous traps with a code, and it strobes every retired instruction. Eight interrupt lines come in from devices. In each cycle the unit decides whether an exception is taken. When one is taken, it saves the return PC, records the cause code, pushes the mode/enable stack into kernel mode with interrupts off, and points fetch at the fixed handler vector.

Software reaches the registers through a read port and a write port, both selected by register number. Writes are accepted only in kernel mode. An exception-return strobe pops the mode/enable stack and sends fetch back to the saved PC. All pins are plain control and status pins with no valid/ready handshake. A strobe is acted on in the cycle it is high, and the pipeline must accept a redirect in the cycle it is shown, because the unit has no means to hold it back.

Top module: `sysctl_unit`

## Requirements
- R1: Register numbers select the registers: 8 is the bad address, 12 is status, 13 is cause and 14 is the return PC. Reading any other number returns zero.
- R2: After reset all four registers read zero. This means kernel mode, every enable and mask bit clear, and cause code 0.
- R3: A trap strobe (`exc_req`) is taken at once, whatever the mode or enable. In the same cycle `redirect` is high and `redirect_pc` is 0x80000180. After the edge, the return PC holds `trap_pc` and cause bits 5:2 hold `exc_code`.
- R4: Taking any exception moves status bits 3:2 into 5:4 and bits 1:0 into 3:2, and it clears bits 1:0. Bit 1 is the mode (1 = user) and bit 0 is the interrupt enable.
- R5: `eret` moves status bits 3:2 into 1:0 and bits 5:4 into 3:2, and it leaves bits 5:4 unchanged. In the same cycle `redirect_pc` equals the saved return PC.
- R6: When status bit 1 is set (user mode), writes to registers 12, 13 and 14 are ignored. Reads still work.
- R7: Cause bits 15:8 show the interrupt lines one cycle later. An interrupt is taken on a cycle with `retire` high only when status bit 0 is set and (cause bits 15:8 AND status mask bits 15:8) is nonzero. It then writes cause code 0 and saves `resume_pc` as the return PC.
- R8: A pending interrupt that is disabled or masked causes no redirect. It is held until the enable and the mask allow it, and it is then taken on the next retire.
- R9: When a trap and an interrupt fall in the same cycle, the trap wins. Its code and `trap_pc` are recorded.
- R10: The bad-address register captures `fault_addr` only for codes 4 and 5. Software writes to it are ignored.
- R11: A kernel status write keeps bits 15:8 and 5:0, and the other bits read zero. A kernel cause write sets only the code field, bits 5:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 8 | Level interrupt requests |
| retire | input | 1 | An instruction retired this cycle |
| resume_pc | input | 32 | Address of the next instruction, saved on an interrupt |
| exc_req | input | 1 | Synchronous trap request |
| exc_code | input | 4 | Cause code of the trap |
| trap_pc | input | 32 | Address of the faulting instruction |
| fault_addr | input | 32 | Faulting memory address |
| eret | input | 1 | Exception-return strobe |
| rd_num | input | 5 | Register number to read |
| rd_data | output | 32 | Read data (combinational) |
| wr_en | input | 1 | Register write strobe |
| wr_num | input | 5 | Register number to write |
| wr_data | input | 32 | Write data |
| redirect | output | 1 | Fetch must load `redirect_pc` |
| redirect_pc | output | 32 | Handler vector or return address |

## Verification
Traps are driven with arithmetic, address and bus-error codes. The cases show whether the bad-address capture depends on the code and whether the stack push works from several starting stack values. An interrupt on one line is tried four ways: enabled and unmasked, disabled, enabled but masked, and then unmasked. These cases separate the roles of the enable bit, the mask and the pending flag. A trap and a retire with an interrupt pending are driven in one cycle to test the priority. Writes made in user mode and in kernel mode show that the privilege check is applied to each register.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int XLEN  = 32;
  localparam int RNUM_W = 5;
  localparam int CODE_W = 4;

  localparam logic [RNUM_W-1:0] RN_BADADDR = 5'd8;
  localparam logic [RNUM_W-1:0] RN_STATUS  = 5'd12;
  localparam logic [RNUM_W-1:0] RN_CAUSE   = 5'd13;
  localparam logic [RNUM_W-1:0] RN_RETPC   = 5'd14;

  localparam logic [CODE_W-1:0] CODE_IRQ      = 4'd0;
  localparam logic [CODE_W-1:0] CODE_ADDR_LD  = 4'd4;
  localparam logic [CODE_W-1:0] CODE_ADDR_ST  = 4'd5;

  // bit positions inside the 6-bit mode/enable stack
  localparam int STK_IE_CUR = 0;
  localparam int STK_KU_CUR = 1;
  localparam int MASK_LSB   = 8;
  localparam int CODE_LSB   = 2;
endpackage

// File: rtl/sysctl_status.sv
module sysctl_status
  import sysctl_pkg::*;
#(
  parameter int IRQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             eret,
  input  logic             wr_ok,
  input  logic [XLEN-1:0]  wr_data,
  output logic [5:0]       stack,
  output logic [IRQ_W-1:0] mask
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stack <= '0;
      mask  <= '0;
    end else if (take) begin
      stack <= {stack[3:0], 2'b00};
    end else if (eret) begin
      stack <= {stack[5:4], stack[5:2]};
    end else if (wr_ok) begin
      stack <= wr_data[5:0];
      mask  <= wr_data[MASK_LSB +: IRQ_W];
    end
  end

  assert_stack_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (stack[5:2] == $past(stack[3:0])) && (stack[1:0] == 2'b00));

  assert_stack_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !take) |=> (stack[1:0] == $past(stack[3:2])) &&
                        (stack[3:2] == $past(stack[5:4])) &&
                        (stack[5:4] == $past(stack[5:4])));

  assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> $stable(mask));
endmodule

// File: rtl/sysctl_arbiter.sv
module sysctl_arbiter
  import sysctl_pkg::*;
#(
  parameter int IRQ_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              retire,
  input  logic              ie_cur,
  input  logic [IRQ_W-1:0]  pending,
  input  logic [IRQ_W-1:0]  mask,
  output logic              take,
  output logic              take_int,
  output logic [CODE_W-1:0] code_sel
);
  logic irq_hit;

  always_comb begin
    irq_hit  = |(pending & mask);
    take_int = retire && ie_cur && irq_hit && !exc_req;
    take     = exc_req || take_int;
    code_sel = exc_req ? exc_code : CODE_IRQ;
  end

  assert_trap_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (take && !take_int && code_sel == exc_code));

  assert_int_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_int |-> (ie_cur && retire && (pending & mask) != '0));
endmodule

// File: rtl/sysctl_cause.sv
module sysctl_cause
  import sysctl_pkg::*;
#(
  parameter int IRQ_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IRQ_W-1:0]  irq_lines,
  input  logic              take,
  input  logic [CODE_W-1:0] code_sel,
  input  logic              wr_ok,
  input  logic [CODE_W-1:0] wr_code,
  output logic [IRQ_W-1:0]  pending,
  output logic [CODE_W-1:0] code
);
  for (genvar g = 0; g < IRQ_W; g++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rst_n) pending[g] <= 1'b0;
      else        pending[g] <= irq_lines[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     code <= '0;
    else if (take)  code <= code_sel;
    else if (wr_ok) code <= wr_code;
  end

  assert_code_on_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> code == $past(code_sel));
endmodule

// File: rtl/sysctl_unit.sv
module sysctl_unit
  import sysctl_pkg::*;
#(
  parameter int              IRQ_W   = 8,
  parameter logic [XLEN-1:0] VEC_ADDR = 32'h8000_0180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IRQ_W-1:0]  irq_lines,
  input  logic              retire,
  input  logic [XLEN-1:0]   resume_pc,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic [XLEN-1:0]   fault_addr,
  input  logic              eret,
  input  logic [RNUM_W-1:0] rd_num,
  output logic [XLEN-1:0]   rd_data,
  input  logic              wr_en,
  input  logic [RNUM_W-1:0] wr_num,
  input  logic [XLEN-1:0]   wr_data,
  output logic              redirect,
  output logic [XLEN-1:0]   redirect_pc
);
  localparam int PAD_HI = XLEN - MASK_LSB - IRQ_W;

  logic [5:0]        stack;
  logic [IRQ_W-1:0]  mask, pending;
  logic [CODE_W-1:0] code, code_sel;
  logic              take, take_int, kernel, wr_allow;
  logic              wr_status, wr_cause, wr_retpc;
  logic [XLEN-1:0]   retpc, badaddr, status_word, cause_word;

  always_comb begin
    kernel    = !stack[STK_KU_CUR];
    wr_allow  = wr_en && kernel && !take && !eret;
    wr_status = wr_allow && (wr_num == RN_STATUS);
    wr_cause  = wr_allow && (wr_num == RN_CAUSE);
    wr_retpc  = wr_allow && (wr_num == RN_RETPC);
  end

  sysctl_arbiter #(.IRQ_W(IRQ_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
    .retire(retire), .ie_cur(stack[STK_IE_CUR]), .pending(pending),
    .mask(mask), .take(take), .take_int(take_int), .code_sel(code_sel)
  );

  sysctl_status #(.IRQ_W(IRQ_W)) u_status (
    .clk(clk), .rst_n(rst_n), .take(take), .eret(eret), .wr_ok(wr_status),
    .wr_data(wr_data), .stack(stack), .mask(mask)
  );

  sysctl_cause #(.IRQ_W(IRQ_W)) u_cause (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .take(take),
    .code_sel(code_sel), .wr_ok(wr_cause), .wr_code(wr_data[CODE_LSB +: CODE_W]),
    .pending(pending), .code(code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      retpc   <= '0;
      badaddr <= '0;
    end else begin
      if (take)          retpc <= take_int ? resume_pc : trap_pc;
      else if (wr_retpc) retpc <= wr_data;
      if (exc_req && (exc_code == CODE_ADDR_LD || exc_code == CODE_ADDR_ST))
        badaddr <= fault_addr;
    end
  end

  always_comb begin
    status_word = {{PAD_HI{1'b0}}, mask, 2'b00, stack};
    cause_word  = {{PAD_HI{1'b0}}, pending, 2'b00, code, 2'b00};
    unique case (rd_num)
      RN_BADADDR: rd_data = badaddr;
      RN_STATUS:  rd_data = status_word;
      RN_CAUSE:   rd_data = cause_word;
      RN_RETPC:   rd_data = retpc;
      default:    rd_data = '0;
    endcase
    redirect    = take || eret;
    redirect_pc = take ? VEC_ADDR : retpc;
  end

  assert_trap_saves_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> retpc == $past(trap_pc));

  assert_badaddr_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && (exc_code == CODE_ADDR_LD || exc_code == CODE_ADDR_ST))
      |=> badaddr == $past(fault_addr));

  assert_user_status_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && stack[STK_KU_CUR] && wr_num == RN_STATUS && !exc_req && !retire && !eret)
      |=> $stable(status_word));

  assert_user_retpc_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && stack[STK_KU_CUR] && !exc_req && !retire && !eret) |=> $stable(retpc));

  assert_vector_on_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !eret) |-> redirect_pc == VEC_ADDR);

  assert_kernel_after_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!stack[STK_KU_CUR] && !stack[STK_IE_CUR]));
endmodule

// File: tb/sysctl_unit_bench.sv
`timescale 1ns/1ps
module sysctl_unit_bench;
  localparam logic [31:0] VEC = 32'h8000_0180;

  logic        clk = 0, rst_n = 0;
  logic [7:0]  irq_lines = '0;
  logic        retire = 0, exc_req = 0, eret = 0, wr_en = 0;
  logic [31:0] resume_pc = '0, trap_pc = '0, fault_addr = '0, wr_data = '0;
  logic [3:0]  exc_code = '0;
  logic [4:0]  rd_num = '0, wr_num = '0;
  logic [31:0] rd_data, redirect_pc;
  logic        redirect;

  sysctl_unit u_sysctl_unit (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .retire(retire),
    .resume_pc(resume_pc), .exc_req(exc_req), .exc_code(exc_code),
    .trap_pc(trap_pc), .fault_addr(fault_addr), .eret(eret),
    .rd_num(rd_num), .rd_data(rd_data), .wr_en(wr_en), .wr_num(wr_num),
    .wr_data(wr_data), .redirect(redirect), .redirect_pc(redirect_pc)
  );

  always #2 clk = ~clk;

  typedef struct {
    int          kind;   // 0 read data, 1 redirect to exp, 2 no redirect
    logic [31:0] exp;
    string       rq;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // monitor: compares one expected item per cycle, mid-cycle
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      case (it.kind)
        0: if (rd_data !== it.exp) begin
             n_fail++;
             $display("FAIL %s: read got %h expected %h", it.rq, rd_data, it.exp);
           end
        1: if (redirect !== 1'b1 || redirect_pc !== it.exp) begin
             n_fail++;
             $display("FAIL %s: redirect %b pc %h expected 1 pc %h",
                      it.rq, redirect, redirect_pc, it.exp);
           end
        default: if (redirect !== 1'b0) begin
             n_fail++;
             $display("FAIL %s: redirect %b expected 0", it.rq, redirect);
           end
      endcase
    end
  end

  task automatic push(int kind, logic [31:0] exp, string rq);
    item_t it;
    it.kind = kind; it.exp = exp; it.rq = rq;
    q.push_back(it);
  endtask

  task automatic step();
    @(posedge clk); #1;
    exc_req = 0; retire = 0; eret = 0; wr_en = 0;
  endtask

  task automatic rd(logic [4:0] n, logic [31:0] exp, string rq);
    step(); rd_num = n; push(0, exp, rq);
  endtask

  task automatic wr(logic [4:0] n, logic [31:0] d);
    step(); wr_en = 1; wr_num = n; wr_data = d;
  endtask

  task automatic trap(logic [3:0] c, logic [31:0] pc, logic [31:0] a, string rq);
    step(); exc_req = 1; exc_code = c; trap_pc = pc; fault_addr = a;
    push(1, VEC, rq);
  endtask

  task automatic ret(logic [31:0] exp_pc, string rq);
    step(); eret = 1; push(1, exp_pc, rq);
  endtask

  task automatic ret_instr(logic [31:0] rpc, bit taken, string rq);
    step(); retire = 1; resume_pc = rpc;
    if (taken) push(1, VEC, rq); else push(2, '0, rq);
  endtask

  task automatic set_irq(logic [7:0] v);
    step(); irq_lines = v;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R2 reset state
    rd(5'd12, 32'h0, "R2 status");
    rd(5'd13, 32'h0, "R2 cause");
    rd(5'd14, 32'h0, "R2 retpc");
    rd(5'd8,  32'h0, "R2 badaddr");
    // R11 status write keeps mask and stack only
    wr(5'd12, 32'hFFFF_AA3C);
    rd(5'd12, 32'h0000_AA3C, "R11 status fields");
    // R3 / R4 overflow trap
    trap(4'd12, 32'h0040_0100, 32'h0000_1234, "R3 vector");
    rd(5'd14, 32'h0040_0100, "R3 retpc");
    rd(5'd13, 32'h0000_0030, "R3 cause code");
    rd(5'd12, 32'h0000_AA30, "R4 push");
    rd(5'd8,  32'h0, "R10 no capture code 12");
    // R10 address trap captures
    trap(4'd4, 32'h0040_0200, 32'hDEAD_BEE0, "R3 vector load fault");
    rd(5'd8,  32'hDEAD_BEE0, "R10 capture code 4");
    rd(5'd12, 32'h0000_AA00, "R4 second push");
    // R5 return pops stack
    wr(5'd12, 32'h0000_AA24);
    ret(32'h0040_0200, "R5 return target");
    rd(5'd12, 32'h0000_AA29, "R5 pop");
    // R6 user mode locks writes
    wr(5'd12, 32'h0000_AA03);
    rd(5'd12, 32'h0000_AA03, "R6 enter user");
    wr(5'd12, 32'h0);
    rd(5'd12, 32'h0000_AA03, "R6 status locked");
    wr(5'd14, 32'h0000_0999);
    rd(5'd14, 32'h0040_0200, "R6 retpc locked");
    wr(5'd13, 32'h0000_003C);
    rd(5'd13, 32'h0000_0010, "R6 cause locked");
    // R7 interrupt taken on retire
    set_irq(8'h02);
    ret_instr(32'h0040_0304, 1'b1, "R7 interrupt taken");
    rd(5'd13, 32'h0000_0200, "R7 cause pending code 0");
    rd(5'd14, 32'h0040_0304, "R7 retpc resume");
    rd(5'd12, 32'h0000_AA0C, "R4 push from user");
    // R8 held while disabled
    ret_instr(32'h0040_0310, 1'b0, "R8 disabled no take");
    wr(5'd12, 32'h0000_5501);
    ret_instr(32'h0040_0320, 1'b0, "R7 masked no take");
    wr(5'd12, 32'h0000_0201);
    ret_instr(32'h0040_0400, 1'b1, "R8 taken after unmask");
    rd(5'd12, 32'h0000_0204, "R8 status after take");
    rd(5'd14, 32'h0040_0400, "R8 retpc");
    // R9 trap beats interrupt
    wr(5'd12, 32'h0000_0201);
    step(); exc_req = 1; exc_code = 4'd7; trap_pc = 32'h0040_0500;
    fault_addr = 32'h0000_0077; retire = 1; resume_pc = 32'h0040_0504;
    push(1, VEC, "R9 redirect");
    rd(5'd13, 32'h0000_021C, "R9 cause code 7");
    rd(5'd14, 32'h0040_0500, "R9 trap pc kept");
    rd(5'd8,  32'hDEAD_BEE0, "R10 no capture code 7");
    // R10 store fault capture, writes ignored
    trap(4'd5, 32'h0040_0600, 32'h0000_0F00, "R3 vector store fault");
    rd(5'd8, 32'h0000_0F00, "R10 capture code 5");
    wr(5'd8, 32'h0000_1234);
    rd(5'd8, 32'h0000_0F00, "R10 write ignored");
    // R11 kernel cause write sets code only
    wr(5'd13, 32'hFFFF_FFFF);
    rd(5'd13, 32'h0000_023C, "R11 cause write");
    set_irq(8'h00);
    rd(5'd13, 32'h0000_003C, "R7 pending follows lines");
    // R1 unknown number
    rd(5'd9, 32'h0, "R1 unmapped read");
    step(); step();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule